// File: doc/BRIEF.md
# Non-Retriggerable Digital One-Shot

This block is a clocked monostable. It watches three control lines: a trigger that acts on its falling edge, a trigger that acts on its rising edge, and an active-low clear. When one of them makes a transition that qualifies, the block raises `q` for a programmable number of clock cycles. `q_n` is always the complement of `q`. A pulse that is running cannot be extended or restarted. Pulling the clear line low ends a pulse at once.

Qualification works as follows. A falling edge on `trig_fall_n` counts only while `trig_rise` is high and `clr_n` is high. A rising edge on `trig_rise` counts only while `trig_fall_n` is low and `clr_n` is high. A rising edge on `clr_n` counts only when `trig_fall_n` is low and `trig_rise` is high, and only after `trig_rise` went high while `clr_n` was still low. That last condition is kept in an internal arming flag.

Each control line passes through a two-flop synchroniser, and edges are detected on the synchronised values. The pulse length is read from `pulse_len` on the clock edge that starts the pulse. For a second channel, instantiate the block twice.

Top module: `oneshot_pulse`

## Requirements
- R1: While `rst_n` is low, `q` is 0 and `q_n` is 1. Edge detection starts only after the synchroniser holds sampled data, which is three clock edges after reset is released.
- R2: A falling edge on `trig_fall_n`, taken while `trig_rise`=1 and `clr_n`=1, starts a pulse. Input changes are driven between edges. `q` rises after the third rising clock edge that follows the change.
- R3: A rising edge on `trig_rise`, taken while `trig_fall_n`=0 and `clr_n`=1, starts a pulse with the same latency as R2.
- R4: A rising edge on `clr_n`, taken while `trig_fall_n`=0 and `trig_rise`=1, starts a pulse only if the arming flag is set. The flag is set when `trig_rise` rises while `clr_n`=0. It is cleared when `trig_rise` is low or when a qualified clear edge fires.
- R5: A rising edge on `clr_n` with no preceding arming rise of `trig_rise` leaves `q` at 0.
- R6: `q` stays high for exactly `pulse_len` cycles, using the value sampled at the start edge. A value of 0 produces no pulse.
- R7: A qualifying trigger that arrives while a pulse is active neither restarts nor lengthens that pulse.
- R8: When `clr_n` goes low, `q` is 0 after the third rising clock edge that follows the change, and it stays 0 while `clr_n` is low.
- R9: `q_n` equals the inverse of `q` at all times.
- R10: Static levels never start a pulse, and neither does a rising edge on `trig_fall_n`, a falling edge on `trig_rise`, or a rising edge on `trig_rise` while `trig_fall_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_fall_n | input | 1 | Trigger that acts on its falling edge |
| trig_rise | input | 1 | Trigger that acts on its rising edge |
| clr_n | input | 1 | Active-low clear; its rising edge can also trigger |
| pulse_len | input | WIDTH | Pulse length in clock cycles, sampled at the start edge |
| q | output | 1 | Pulse output, high while a pulse is active |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench builds the block with WIDTH=4. With that width, random stimulus covers every pulse length from 0 to the maximum of 15, and the longest pulses are short enough that retriggers and clears overlap them often. Random toggles of the three control lines are compared every cycle against a reference model in the bench. Directed sequences cover the arming precondition, early clear, the single-cycle pulse and the zero-length pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic fall_n;
    logic rise;
    logic clr_n;
  } ctl_t;

  localparam int CTL_BITS = $bits(ctl_t);
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv,
  output logic         ready
);
  logic [N-1:0]  stg_q [STAGES];
  logic [N-1:0]  prv_q;
  logic [STAGES:0] rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prv_q <= '0;
      rdy_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prv_q <= stg_q[STAGES-1];
      rdy_q <= {rdy_q[STAGES-1:0], 1'b1};
    end
  end

  assign cur   = stg_q[STAGES-1];
  assign prv   = prv_q;
  assign ready = rdy_q[STAGES];
endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t cur,
  input  ctl_t prv,
  input  logic ready,
  output logic fire
);
  logic armed_q, armed_d, armed_en;
  logic edge_fall, edge_rise, edge_clr, arm_set;

  always_comb begin
    edge_fall = ready & prv.fall_n & ~cur.fall_n & cur.rise & cur.clr_n;
    edge_rise = ready & ~prv.rise & cur.rise & ~cur.fall_n & cur.clr_n;
    edge_clr  = ready & ~prv.clr_n & cur.clr_n & ~cur.fall_n & cur.rise & armed_q;
    arm_set   = ready & ~prv.rise & cur.rise & ~cur.clr_n;
    fire      = edge_fall | edge_rise | edge_clr;
  end

  always_comb begin
    armed_en = 1'b0;
    armed_d  = armed_q;
    if (!cur.rise || edge_clr) begin
      armed_en = 1'b1;
      armed_d  = 1'b0;
    end else if (arm_set) begin
      armed_en = 1'b1;
      armed_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  // R4: the arming flag only comes up after a rise seen while clear is low
  p_arm_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(!cur.clr_n && cur.rise));
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_ok,
  input  logic             fire,
  input  logic [WIDTH-1:0] len,
  output logic             active
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             active_q, active_d;
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (!clr_ok) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_d = 1'b0;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - ONE;
      end
    end else if (fire && (len != '0)) begin
      active_d = 1'b1;
      cnt_en   = 1'b1;
      cnt_d    = len - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active = active_q;

  p_clear_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok |=> !active_q);

  p_no_extend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0 && clr_ok) |=> (active_q && cnt_q == $past(cnt_q) - ONE));

  p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && fire && len == '0) |=> !active_q);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !fire) |=> !active_q);
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_fall_n,
  input  logic             trig_rise,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] pulse_len,
  output logic             q,
  output logic             q_n
);
  ctl_t raw, cur, prv;
  logic [CTL_BITS-1:0] cur_v, prv_v;
  logic ready, fire, active;

  assign raw = '{fall_n: trig_fall_n, rise: trig_rise, clr_n: clr_n};

  oneshot_sync #(.N(CTL_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .cur(cur_v), .prv(prv_v), .ready(ready)
  );

  assign cur = ctl_t'(cur_v);
  assign prv = ctl_t'(prv_v);

  oneshot_trig u_trig (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prv(prv), .ready(ready), .fire(fire)
  );

  oneshot_timer #(.WIDTH(WIDTH)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_ok(cur.clr_n), .fire(fire),
    .len(pulse_len), .active(active)
  );

  assign q   = active;
  assign q_n = ~active;

  // R1: outputs at rest during reset
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (q == 1'b0 && q_n == 1'b1);
    end
  end
endmodule

// File: tb/oneshot_pulse_test.sv
`timescale 1ns/1ps
module oneshot_pulse_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic a_n, b, c_n;
  logic [W-1:0] len;
  logic q, q_n;
  int errors = 0;
  int checks = 0;
  logic chk_en = 1'b0;

  always #2 clk = ~clk;

  oneshot_pulse #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .trig_fall_n(a_n), .trig_rise(b), .clr_n(c_n),
    .pulse_len(len), .q(q), .q_n(q_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  logic [2:0] h0, h1, h2;
  logic m_act, m_arm;
  logic [W-1:0] m_cnt;
  always @(posedge clk) begin
    logic pa, pb, pc, ca, cb, cc, tf, tr, tc, fire;
    if (!rst_n) begin
      m_act = 1'b0; m_arm = 1'b0; m_cnt = '0;
      h0 = {a_n, b, c_n}; h1 = h0; h2 = h0;
    end else begin
      {ca, cb, cc} = h1;
      {pa, pb, pc} = h2;
      tf = pa & ~ca & cb & cc;
      tr = ~pb & cb & ~ca & cc;
      tc = ~pc & cc & ~ca & cb & m_arm;
      fire = tf | tr | tc;
      if (!cb || tc) m_arm = 1'b0;
      else if (~pb & cb & ~cc) m_arm = 1'b1;
      if (!cc) m_act = 1'b0;
      else if (m_act) begin
        if (m_cnt == 0) m_act = 1'b0; else m_cnt = m_cnt - 1'b1;
      end else if (fire && len != 0) begin
        m_act = 1'b1; m_cnt = len - 1'b1;
      end
      h2 = h1; h1 = h0; h0 = {a_n, b, c_n};
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(q, m_act, "R7 model");
      check(q_n, ~q, "R9");
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_pulse(input int l, input string tag);
    wait_n(2); check(q, 1'b0, tag);
    wait_n(1); check(q, 1'b1, tag);
    wait_n(l - 1); check(q, 1'b1, tag);
    wait_n(1); check(q, 1'b0, tag);
  endtask

  initial begin
    a_n = 1'b1; b = 1'b0; c_n = 1'b1; len = W'(5);
    rst_n = 1'b0;
    void'($urandom(32'd4242));
    wait_n(3);
    check(q, 1'b0, "R1"); check(q_n, 1'b1, "R1");
    rst_n = 1'b1;
    wait_n(6);
    chk_en = 1'b1;
    check(q, 1'b0, "R1");

    // R10: B rises while A high
    b = 1'b1; wait_n(8); check(q, 1'b0, "R10");
    // R2: A falls with B and clear high
    a_n = 1'b0; expect_pulse(5, "R2");
    wait_n(3);
    // R10: B falls, no trigger
    b = 1'b0; wait_n(6); check(q, 1'b0, "R10");
    // R3: B rises with A low
    b = 1'b1; expect_pulse(5, "R3");
    wait_n(3);
    // R7: retrigger inside a pulse
    a_n = 1'b1; wait_n(5);
    a_n = 1'b0; wait_n(3); check(q, 1'b1, "R7");
    b = 1'b0; wait_n(1); b = 1'b1;
    wait_n(4); check(q, 1'b0, "R7");
    wait_n(3); check(q, 1'b0, "R7");
    // R8: clear ends a pulse early
    a_n = 1'b1; wait_n(5);
    a_n = 1'b0; wait_n(3); check(q, 1'b1, "R8");
    c_n = 1'b0; wait_n(2); check(q, 1'b1, "R8");
    wait_n(1); check(q, 1'b0, "R8");
    wait_n(6); check(q, 1'b0, "R8");
    // R5: clear rises without arming
    c_n = 1'b1; wait_n(8); check(q, 1'b0, "R5");
    // R4: arm under clear, then release clear
    c_n = 1'b0; wait_n(4);
    b = 1'b0; wait_n(4);
    b = 1'b1; wait_n(4); check(q, 1'b0, "R4");
    c_n = 1'b1; expect_pulse(5, "R4");
    wait_n(3);
    // R6: length 1 and length 0
    a_n = 1'b1; len = W'(1); wait_n(5);
    a_n = 1'b0; expect_pulse(1, "R6");
    a_n = 1'b1; len = W'(15); wait_n(5);
    a_n = 1'b0; expect_pulse(15, "R6");
    a_n = 1'b1; len = W'(0); wait_n(5);
    a_n = 1'b0; wait_n(3); check(q, 1'b0, "R6");
    wait_n(5); check(q, 1'b0, "R6");

    // Random phase, checked by the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) begin
        case ($urandom_range(0, 2))
          0: a_n = ~a_n;
          1: b = ~b;
          default: c_n = ~c_n;
        endcase
      end
      if ($urandom_range(0, 19) == 0) len = W'($urandom_range(0, 15));
    end
    wait_n(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule